// File: doc/BRIEF.md
# Instruction/Data Tightly-Coupled Memory Arbiter

This block lets a processor's fetch path and its load/store path share one single-port synchronous word memory. Each path has its own request bus: a select strobe, a 4-lane byte mask, a 32-bit address and, on the data side only, a write strobe and write data. Each cycle the arbiter admits at most one request to the memory by fixed priority. Stores win over loads, and loads win over fetches. The response comes back one clock later on the bus that won.

The path is pipelined one level deep. A request admitted at a clock edge gets its acknowledge, and for a read its data, in the following cycle. In that same cycle the requester may present its next request. A requester that gets no acknowledge must keep its request unchanged. A debug-stall input freezes the arbiter: while it is high nothing is admitted and both response registers stay clear. A select with an empty byte mask is refused. It gets an error response and never touches the memory. The behavioural memory holds 2048 words of 32 bits and is indexed by address bits 12 down to 2.

Top module: `tcm_arbiter`

## Requirements
- R1: When several eligible requests coincide, the grant goes to a data write (`d_sel`=1, `d_we`=1) first, then to a data read (`d_sel`=1, `d_we`=0), then to a fetch (`i_sel`=1). A request is eligible when its byte mask is nonzero. Only the granted side is acknowledged in the next cycle.
- R2: A granted read (data load or fetch) raises its side's acknowledge one clock after the edge at which it was admitted. In that same cycle the read-data output carries the memory word addressed at admission.
- R3: A granted data write updates only the byte lanes whose mask bit is 1. Mask bit k covers data bits 8k+7 down to 8k. The other lanes keep their old contents.
- R4: `d_ack` and `i_ack` are never high in the same cycle. A fetch that loses to a data request gets no acknowledge for that cycle.
- R5: If `dbg_stall` is high at a clock edge, no request is admitted at that edge. All of `d_ack`, `i_ack`, `d_err` and `i_err` are low in the next cycle, and a store presented at that edge does not change the memory.
- R6: A select with an all-zero byte mask on either side, presented at an edge without stall, gives that side's error (and no acknowledge) in the next cycle. The memory is not accessed, and the request does not block the other side.
- R7: `d_retry` is high exactly when `d_sel` is high and `d_ack` is low.
- R8: While `rst_n` is low, both acknowledges and both errors are low.
- R9: The word index is address bits 12 down to 2. Address bits 1:0 and bits above 12 do not affect which word is accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dbg_stall | input | 1 | Debug stall: blocks admission and clears responses |
| d_sel | input | 1 | Data request select |
| d_we | input | 1 | Data request is a write |
| d_be | input | 4 | Data byte-lane mask |
| d_addr | input | 32 | Data byte address |
| d_wdata | input | 32 | Data write data |
| d_rdata | output | 32 | Data read data, valid with `d_ack` after a load |
| d_ack | output | 1 | Data acknowledge |
| d_err | output | 1 | Data error (empty byte mask) |
| d_retry | output | 1 | Data request pending without acknowledge |
| i_sel | input | 1 | Fetch request select |
| i_be | input | 4 | Fetch byte-lane mask |
| i_addr | input | 32 | Fetch byte address |
| i_rdata | output | 32 | Fetch read data, valid with `i_ack` |
| i_ack | output | 1 | Fetch acknowledge |
| i_err | output | 1 | Fetch error (empty byte mask) |

## Verification
The bench drives coincident store/fetch and load/fetch requests. A priority mix-up would acknowledge the fetch, or both sides at once. Partial-mask stores followed by full reads expose a design that writes whole words. A store held under debug stall, then read back, catches a memory that is written while acknowledges are suppressed. An empty-mask data request paired with a live fetch shows whether the refused request wrongly occupies the memory or starves the fetch. Aliased addresses with high bits and low bits set catch a wrong index slice.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

   typedef enum logic [1:0] {
      GNT_NONE  = 2'd0,
      GNT_STORE = 2'd1,
      GNT_LOAD  = 2'd2,
      GNT_FETCH = 2'd3
   } gnt_e;

endpackage

// File: rtl/tcm_prio_arb.sv
module tcm_prio_arb
   import tcm_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             stall,
   input  logic             d_sel,
   input  logic             d_we,
   input  logic [LANES-1:0] d_be,
   input  logic             i_sel,
   input  logic [LANES-1:0] i_be,
   output gnt_e             gnt,
   output logic             d_bad,
   output logic             i_bad
);

   logic d_ok;
   logic i_ok;

   // a request is eligible only with at least one lane enabled
   assign d_ok  = d_sel && (|d_be);
   assign i_ok  = i_sel && (|i_be);
   assign d_bad = d_sel && !(|d_be);
   assign i_bad = i_sel && !(|i_be);

   always_comb begin
      gnt = GNT_NONE;
      if (!stall) begin
         if (d_ok && d_we)      gnt = GNT_STORE;
         else if (d_ok)         gnt = GNT_LOAD;
         else if (i_ok)         gnt = GNT_FETCH;
      end
   end

endmodule

// File: rtl/tcm_port_mux.sv
module tcm_port_mux
   import tcm_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int LANES  = 4,
   parameter int IDX_W  = 11,
   parameter int OFS_W  = 2
) (
   input  gnt_e              gnt,
   input  logic [ADDR_W-1:0] d_addr,
   input  logic [LANES-1:0]  d_be,
   input  logic [DATA_W-1:0] d_wdata,
   input  logic [ADDR_W-1:0] i_addr,
   input  logic [LANES-1:0]  i_be,
   output logic              mem_en,
   output logic              mem_we,
   output logic [LANES-1:0]  mem_be,
   output logic [IDX_W-1:0]  mem_idx,
   output logic [DATA_W-1:0] mem_wdata
);

   logic [IDX_W-1:0] d_idx;
   logic [IDX_W-1:0] i_idx;

   assign d_idx     = d_addr[OFS_W +: IDX_W];
   assign i_idx     = i_addr[OFS_W +: IDX_W];
   assign mem_wdata = d_wdata;

   always_comb begin
      mem_en  = 1'b0;
      mem_we  = 1'b0;
      mem_be  = '0;
      mem_idx = '0;
      unique case (gnt)
         GNT_STORE: begin
            mem_en  = 1'b1;
            mem_we  = 1'b1;
            mem_be  = d_be;
            mem_idx = d_idx;
         end
         GNT_LOAD: begin
            mem_en  = 1'b1;
            mem_be  = d_be;
            mem_idx = d_idx;
         end
         GNT_FETCH: begin
            // the fetch side is read-only
            mem_en  = 1'b1;
            mem_be  = i_be;
            mem_idx = i_idx;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/tcm_word_ram.sv
module tcm_word_ram #(
   parameter int DATA_W = 32,
   parameter int WORDS  = 2048,
   parameter int IDX_W  = 11
) (
   input  logic              clk,
   input  logic              en,
   input  logic              we,
   input  logic [DATA_W/8-1:0] be,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int LANES = DATA_W / 8;

   // one independent byte-wide array per lane
   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      logic [7:0] arr [WORDS];
      logic [7:0] rd_q;

      always_ff @(posedge clk) begin
         if (en && we && be[ln])
            arr[idx] <= wdata[ln*8 +: 8];
         if (en && !we)
            rd_q <= arr[idx];
      end

      assign rdata[ln*8 +: 8] = rd_q;
   end

endmodule

// File: rtl/tcm_side_resp.sv
module tcm_side_resp (
   input  logic clk,
   input  logic rst_n,
   input  logic stall,
   input  logic ack_set,
   input  logic err_set,
   output logic ack,
   output logic err
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack <= 1'b0;
         err <= 1'b0;
      end else if (stall) begin
         ack <= 1'b0;
         err <= 1'b0;
      end else begin
         ack <= ack_set;
         err <= err_set;
      end
   end

endmodule

// File: rtl/tcm_arbiter.sv
module tcm_arbiter
   import tcm_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int MEM_WORDS = 2048
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dbg_stall,
   input  logic              d_sel,
   input  logic              d_we,
   input  logic [DATA_W/8-1:0] d_be,
   input  logic [ADDR_W-1:0] d_addr,
   input  logic [DATA_W-1:0] d_wdata,
   output logic [DATA_W-1:0] d_rdata,
   output logic              d_ack,
   output logic              d_err,
   output logic              d_retry,
   input  logic              i_sel,
   input  logic [DATA_W/8-1:0] i_be,
   input  logic [ADDR_W-1:0] i_addr,
   output logic [DATA_W-1:0] i_rdata,
   output logic              i_ack,
   output logic              i_err
);

   localparam int LANES = DATA_W / 8;
   localparam int IDX_W = $clog2(MEM_WORDS);
   localparam int OFS_W = $clog2(LANES);

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("tcm_arbiter: DATA_W must be a multiple of 8");
   end
   if (MEM_WORDS != (1 << IDX_W)) begin : g_bad_depth
      $error("tcm_arbiter: MEM_WORDS must be a power of two");
   end
   if (OFS_W + IDX_W > ADDR_W) begin : g_bad_addr
      $error("tcm_arbiter: address too narrow for memory depth");
   end

   gnt_e              gnt;
   logic              d_bad;
   logic              i_bad;
   logic              mem_en;
   logic              mem_we;
   logic [LANES-1:0]  mem_be;
   logic [IDX_W-1:0]  mem_idx;
   logic [DATA_W-1:0] mem_wdata;
   logic [DATA_W-1:0] mem_rdata;

   tcm_prio_arb #(.LANES(LANES)) u_arb (
      .stall (dbg_stall),
      .d_sel (d_sel),
      .d_we  (d_we),
      .d_be  (d_be),
      .i_sel (i_sel),
      .i_be  (i_be),
      .gnt   (gnt),
      .d_bad (d_bad),
      .i_bad (i_bad)
   );

   tcm_port_mux #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LANES  (LANES),
      .IDX_W  (IDX_W),
      .OFS_W  (OFS_W)
   ) u_mux (
      .gnt       (gnt),
      .d_addr    (d_addr),
      .d_be      (d_be),
      .d_wdata   (d_wdata),
      .i_addr    (i_addr),
      .i_be      (i_be),
      .mem_en    (mem_en),
      .mem_we    (mem_we),
      .mem_be    (mem_be),
      .mem_idx   (mem_idx),
      .mem_wdata (mem_wdata)
   );

   tcm_word_ram #(
      .DATA_W (DATA_W),
      .WORDS  (MEM_WORDS),
      .IDX_W  (IDX_W)
   ) u_ram (
      .clk   (clk),
      .en    (mem_en),
      .we    (mem_we),
      .be    (mem_be),
      .idx   (mem_idx),
      .wdata (mem_wdata),
      .rdata (mem_rdata)
   );

   tcm_side_resp u_dresp (
      .clk     (clk),
      .rst_n   (rst_n),
      .stall   (dbg_stall),
      .ack_set (gnt == GNT_STORE || gnt == GNT_LOAD),
      .err_set (d_bad),
      .ack     (d_ack),
      .err     (d_err)
   );

   tcm_side_resp u_iresp (
      .clk     (clk),
      .rst_n   (rst_n),
      .stall   (dbg_stall),
      .ack_set (gnt == GNT_FETCH),
      .err_set (i_bad),
      .ack     (i_ack),
      .err     (i_err)
   );

   assign d_rdata = mem_rdata;
   assign i_rdata = mem_rdata;
   assign d_retry = d_sel && !d_ack;

endmodule

// File: rtl/tcm_arbiter_chk.sv
module tcm_arbiter_chk #(
   parameter int LANES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dbg_stall,
   input logic             d_sel,
   input logic             d_we,
   input logic [LANES-1:0] d_be,
   input logic             d_ack,
   input logic             d_err,
   input logic             d_retry,
   input logic             i_sel,
   input logic [LANES-1:0] i_be,
   input logic             i_ack,
   input logic             i_err
);

   // R4
   one_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(d_ack && i_ack));

   // R1
   data_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (d_sel && (|d_be) && !dbg_stall) |=> (d_ack && !i_ack));

   // R5
   stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_stall |=> (!d_ack && !i_ack && !d_err && !i_err));

   // R6
   empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (d_sel && !(|d_be) && !dbg_stall) |=> (d_err && !d_ack));

   // R2
   fetch_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (i_sel && (|i_be) && !d_sel && !dbg_stall) |=> i_ack);

   // R7
   retry_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      d_retry |-> d_sel);

   // R6
   err_ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(i_ack && i_err) && !(d_ack && d_err));

   // R1
   store_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (d_sel && d_we && (|d_be) && i_sel && !dbg_stall) |=> !i_ack);

endmodule

bind tcm_arbiter tcm_arbiter_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/tb_tcm_arbiter.sv
module tb_tcm_arbiter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dbg_stall = 1'b0;
   logic        d_sel = 1'b0;
   logic        d_we = 1'b0;
   logic [3:0]  d_be = '0;
   logic [31:0] d_addr = '0;
   logic [31:0] d_wdata = '0;
   logic [31:0] d_rdata;
   logic        d_ack, d_err, d_retry;
   logic        i_sel = 1'b0;
   logic [3:0]  i_be = '0;
   logic [31:0] i_addr = '0;
   logic [31:0] i_rdata;
   logic        i_ack, i_err;

   int    total = 0;
   int    bad = 0;
   bit    done = 1'b0;
   string tag = "R8";

   // reference state
   logic [31:0] ref_mem [2048];
   bit          known [2048];
   logic        e_dack = 0, e_iack = 0, e_derr = 0, e_ierr = 0;
   logic [31:0] e_rd = '0;
   bit          e_rdv = 0;

   always #5 clk = ~clk;

   tcm_arbiter dut (
      .clk(clk), .rst_n(rst_n), .dbg_stall(dbg_stall),
      .d_sel(d_sel), .d_we(d_we), .d_be(d_be), .d_addr(d_addr),
      .d_wdata(d_wdata), .d_rdata(d_rdata), .d_ack(d_ack), .d_err(d_err),
      .d_retry(d_retry), .i_sel(i_sel), .i_be(i_be), .i_addr(i_addr),
      .i_rdata(i_rdata), .i_ack(i_ack), .i_err(i_err)
   );

   // behavioural model: one request served per edge, data side first
   always @(posedge clk) begin
      if (!rst_n) begin
         e_dack <= 0; e_iack <= 0; e_derr <= 0; e_ierr <= 0; e_rdv <= 0;
      end else if (dbg_stall) begin
         e_dack <= 0; e_iack <= 0; e_derr <= 0; e_ierr <= 0; e_rdv <= 0;
      end else begin
         int di, ii;
         di = int'(d_addr[12:2]);
         ii = int'(i_addr[12:2]);
         e_derr <= d_sel && (d_be == 0);
         e_ierr <= i_sel && (i_be == 0);
         e_dack <= 0; e_iack <= 0; e_rdv <= 0;
         if (d_sel && d_be != 0) begin
            e_dack <= 1;
            if (d_we) begin
               for (int k = 0; k < 4; k++)
                  if (d_be[k]) ref_mem[di][k*8 +: 8] = d_wdata[k*8 +: 8];
               if (d_be != 4'hF && !known[di]) known[di] = 0;
               else known[di] = 1;
            end else begin
               e_rd  <= ref_mem[di];
               e_rdv <= known[di];
            end
         end else if (i_sel && i_be != 0) begin
            e_iack <= 1;
            e_rd   <= ref_mem[ii];
            e_rdv  <= known[ii];
         end
      end
   end

   task automatic chk1(input string nm, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s got=%b exp=%b t=%0t", tag, nm, act, exp, $time);
      end
   endtask

   task automatic chk32(input string nm, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s got=%h exp=%h t=%0t", tag, nm, act, exp, $time);
      end
   endtask

   // compare every cycle, half a period after the edge
   always @(negedge clk) begin
      if (!done) begin
         chk1("d_ack", d_ack, e_dack);
         chk1("i_ack", i_ack, e_iack);
         chk1("d_err", d_err, e_derr);
         chk1("i_err", i_err, e_ierr);
         chk1("d_retry", d_retry, d_sel && !e_dack);
         if (e_dack && e_rdv) chk32("d_rdata", d_rdata, e_rd);
         if (e_iack && e_rdv) chk32("i_rdata", i_rdata, e_rd);
      end
   end

   task automatic step(input logic ds, input logic dw, input logic [3:0] dbe,
                       input logic [31:0] da, input logic [31:0] dwd,
                       input logic is, input logic [3:0] ibe, input logic [31:0] ia,
                       input logic st);
      @(posedge clk);
      #1;
      d_sel = ds; d_we = dw; d_be = dbe; d_addr = da; d_wdata = dwd;
      i_sel = is; i_be = ibe; i_addr = ia; dbg_stall = st;
   endtask

   task automatic idle();
      step(0, 0, 4'h0, 32'h0, 32'h0, 0, 4'h0, 32'h0, 0);
   endtask

   initial begin
      for (int k = 0; k < 2048; k++) begin
         ref_mem[k] = '0;
         known[k] = 0;
      end
      // R8: responses quiet under reset
      tag = "R8";
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R2: fill words, then read back through both sides
      tag = "R2";
      step(1, 1, 4'hF, 32'h0000_0000, 32'h1111_0000, 0, 4'h0, 32'h0, 0);
      step(1, 1, 4'hF, 32'h0000_0004, 32'h2222_0004, 0, 4'h0, 32'h0, 0);
      step(1, 1, 4'hF, 32'h0000_0008, 32'h3333_0008, 0, 4'h0, 32'h0, 0);
      step(1, 1, 4'hF, 32'h0000_000C, 32'h4444_000C, 0, 4'h0, 32'h0, 0);
      step(1, 1, 4'hF, 32'h0000_1FFC, 32'hDEAD_BEEF, 0, 4'h0, 32'h0, 0);
      step(1, 0, 4'hF, 32'h0000_0004, 32'h0, 0, 4'h0, 32'h0, 0);
      step(1, 0, 4'hF, 32'h0000_1FFC, 32'h0, 0, 4'h0, 32'h0, 0);
      step(0, 0, 4'h0, 32'h0, 32'h0, 1, 4'hF, 32'h0000_0008, 0);
      step(0, 0, 4'h0, 32'h0, 32'h0, 1, 4'hF, 32'h0000_000C, 0);
      step(1, 0, 4'hF, 32'h0000_0000, 32'h0, 0, 4'h0, 32'h0, 0);
      step(0, 0, 4'h0, 32'h0, 32'h0, 1, 4'hF, 32'h0000_1FFC, 0);
      idle();

      // R3: partial-lane writes keep the other lanes
      tag = "R3";
      step(1, 1, 4'h1, 32'h0000_0004, 32'hAABB_CCDD, 0, 4'h0, 32'h0, 0);
      step(1, 0, 4'hF, 32'h0000_0004, 32'h0, 0, 4'h0, 32'h0, 0);
      step(1, 1, 4'hA, 32'h0000_0008, 32'h5566_7788, 0, 4'h0, 32'h0, 0);
      step(1, 0, 4'hF, 32'h0000_0008, 32'h0, 0, 4'h0, 32'h0, 0);
      step(1, 1, 4'h4, 32'h0000_0000, 32'h00EE_0000, 0, 4'h0, 32'h0, 0);
      step(0, 0, 4'h0, 32'h0, 32'h0, 1, 4'hF, 32'h0000_0000, 0);
      idle();

      // R1: store and load each beat a simultaneous fetch
      tag = "R1";
      step(1, 1, 4'hF, 32'h0000_0010, 32'h0BAD_F00D, 1, 4'hF, 32'h0000_0000, 0);
      step(1, 0, 4'hF, 32'h0000_0010, 32'h0, 1, 4'hF, 32'h0000_0000, 0);
      step(0, 0, 4'h0, 32'h0, 32'h0, 1, 4'hF, 32'h0000_0000, 0);
      idle();

      // R4: a fetch held against continuous data traffic is never acknowledged
      tag = "R4";
      for (int k = 0; k < 4; k++)
         step(1, k[0], 4'hF, 32'h0000_000C, 32'h4444_000C, 1, 4'hF, 32'h0000_0004, 0);
      step(0, 0, 4'h0, 32'h0, 32'h0, 1, 4'hF, 32'h0000_0004, 0);
      idle();

      // R5: store under stall leaves memory alone; responses stay low
      tag = "R5";
      step(1, 1, 4'hF, 32'h0000_0000, 32'hFFFF_FFFF, 1, 4'hF, 32'h0000_0008, 1);
      step(1, 1, 4'hF, 32'h0000_0000, 32'hFFFF_FFFF, 1, 4'h0, 32'h0000_0008, 1);
      step(0, 0, 4'h0, 32'h0, 32'h0, 1, 4'hF, 32'h0000_0000, 0);
      step(1, 0, 4'h0, 32'h0, 32'h0, 0, 4'h0, 32'h0, 1);
      idle();

      // R6: empty mask refused, fetch served in the same cycle
      tag = "R6";
      step(1, 1, 4'h0, 32'h0000_0004, 32'h9999_9999, 1, 4'hF, 32'h0000_0008, 0);
      step(0, 0, 4'h0, 32'h0, 32'h0, 1, 4'h0, 32'h0000_0008, 0);
      step(1, 0, 4'hF, 32'h0000_0004, 32'h0, 0, 4'h0, 32'h0, 0);
      step(1, 0, 4'h0, 32'h0000_0004, 32'h0, 1, 4'h0, 32'h0, 0);
      idle();

      // R7: retry follows a pending data select
      tag = "R7";
      step(1, 0, 4'hF, 32'h0000_0008, 32'h0, 0, 4'h0, 32'h0, 1);
      step(1, 0, 4'hF, 32'h0000_0008, 32'h0, 0, 4'h0, 32'h0, 1);
      step(1, 0, 4'hF, 32'h0000_0008, 32'h0, 0, 4'h0, 32'h0, 0);
      step(0, 0, 4'h0, 32'h0, 32'h0, 1, 4'hF, 32'h0, 1);
      idle();

      // R9: high address bits and byte offset do not change the word
      tag = "R9";
      step(1, 1, 4'hF, 32'hFFFF_E010, 32'hC0DE_CAFE, 0, 4'h0, 32'h0, 0);
      step(1, 0, 4'hF, 32'h0000_0013, 32'h0, 0, 4'h0, 32'h0, 0);
      step(0, 0, 4'h0, 32'h0, 32'h0, 1, 4'hF, 32'h8000_2011, 0);
      step(1, 0, 4'hF, 32'h0000_2010, 32'h0, 1, 4'hF, 32'h0000_0010, 0);
      idle();
      idle();
      @(posedge clk);
      @(negedge clk);
      #1;
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: run did not complete got=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule